// File: doc/BRIEF.md
# Single-Edge Capture and Reference Retiming

This block sits between a delayed reference edge and a fine time-to-digital converter. It lets through exactly one edge of the divided oscillator clock in each reference period: the first divided edge at or after the delayed reference rises. The fine converter therefore runs at the reference rate, not at the oscillator rate. The block also makes a retimed reference pulse from the captured edge. That pulse samples the integer phase counter a fixed number of divided edges later, which gives the converter time to settle.

The block is synchronous logic. It runs on a base clock, and a qualifier input marks the base cycles that carry a divided-oscillator edge. The delayed reference arrives already timed to this clock. A capture-done flag shows that the current period's edge has been forwarded. A missed-edge pulse reports a reference period that ended before any divided edge arrived. An active-low asynchronous reset returns the block to idle and disarmed.

Top module: `snap_edge_capture`

## Requirements
- R1: After the tick on which the block detects a rise of `ref_dly` (sampled 1 after being sampled 0), the block is armed. The first tick on which it is armed and `osc_edge` is 1 is the capture tick; the rise tick itself counts. `cap_edge` is 1 for exactly the one cycle that follows the capture tick.
- R2: After a capture, the block ignores further `osc_edge` ticks: `cap_edge` stays 0 until a new rise of `ref_dly`.
- R3: `ref_rt` is a pulse one cycle wide. It follows the RETIME_LAT-th `osc_edge` tick after the capture tick, with RETIME_LAT = 2 by default. It occurs only if `ref_dly` was 1 on the capture tick; otherwise no pulse comes out.
- R4: `cap_done` goes to 1 in the same cycle as `cap_edge`. It holds until the tick of the next rise, unless that rise tick is also a capture tick. It is 0 from reset until the first capture.
- R5: When a rise of `ref_dly` comes while the block is still armed, `edge_missed` is 1 for the one cycle after that tick. The block stays armed for the new period.
- R6: While `rst_n` is 0, all outputs are 0 and the block is disarmed. If `ref_dly` is already 1 when reset is released, the block does not treat it as a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_div | input | 1 | Base clock of the block |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_dly | input | 1 | Delayed reference level, already timed to clk_div |
| osc_edge | input | 1 | Marks a base cycle that carries a divided-oscillator edge |
| cap_edge | output | 1 | One-cycle pulse for the single forwarded oscillator edge |
| ref_rt | output | 1 | One-cycle retimed reference pulse |
| cap_done | output | 1 | This period's edge has been forwarded |
| edge_missed | output | 1 | One-cycle pulse: the previous period had no divided edge |

## Verification
The bench builds the block with its default retiming latency of two divided edges. It sweeps three settings in combination: the gap from the reference rise to the first divided edge, from zero to four ticks; the spacing of divided edges, from one to three ticks; and how long the reference stays high. Through these sweeps it reaches the capture on the rise tick itself, the later divided edges that must be ignored, and a reference that falls before the capture and so suppresses the retimed pulse. Directed sequences cover back-to-back rises with no divided edge between them and a reference held high through reset.

// File: rtl/snap_pkg.sv
package snap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_DONE  = 2'd2
   } snap_state_t;
endpackage

// File: rtl/snap_rise_det.sv
module snap_rise_det #(
   parameter bit RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic lvl_prev;

   // Previous level resets high so a reference held high through reset is not a rise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= RESET_LEVEL;
      else        lvl_prev <= lvl;
   end

   assign rise = lvl & ~lvl_prev;
endmodule

// File: rtl/snap_arm_ctl.sv
module snap_arm_ctl
   import snap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   input  logic osc_edge,
   output logic capture,
   output logic cap_q,
   output logic done,
   output logic missed_q
);
   snap_state_t state_q, state_d;
   logic        armed_eff;

   // A rise arms the capture in the same tick, so the rise tick's own edge can be taken.
   assign armed_eff = (state_q == ST_ARMED) | rise;
   assign capture   = armed_eff & osc_edge;

   always_comb begin
      state_d = state_q;
      if (capture)   state_d = ST_DONE;
      else if (rise) state_d = ST_ARMED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cap_q    <= 1'b0;
         missed_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         cap_q    <= capture;
         missed_q <= rise & (state_q == ST_ARMED);
      end
   end

   assign done = (state_q == ST_DONE);
endmodule

// File: rtl/snap_retime_pipe.sv
module snap_retime_pipe #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic sample,
   output logic pulse_q
);
   generate
      if (LAT == 1) begin : g_single
         logic stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q   <= 1'b0;
               pulse_q <= 1'b0;
            end else begin
               pulse_q <= adv & stg_q;
               if (adv) stg_q <= sample;
            end
         end
      end else begin : g_chain
         logic [LAT-1:0] stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q   <= '0;
               pulse_q <= 1'b0;
            end else begin
               pulse_q <= adv & stg_q[LAT-1];
               if (adv) stg_q <= {stg_q[LAT-2:0], sample};
            end
         end
      end
   endgenerate
endmodule

// File: rtl/snap_edge_capture.sv
module snap_edge_capture #(
   parameter int RETIME_LAT = 2,
   parameter bit REF_RESET_LEVEL = 1'b1
) (
   input  logic clk_div,
   input  logic rst_n,
   input  logic ref_dly,
   input  logic osc_edge,
   output logic cap_edge,
   output logic ref_rt,
   output logic cap_done,
   output logic edge_missed
);
   localparam int MAX_LAT = 8;

   generate
      if (RETIME_LAT < 1 || RETIME_LAT > MAX_LAT) begin : g_bad_lat
         $error("snap_edge_capture: RETIME_LAT out of range");
      end
   endgenerate

   logic rise;
   logic capture;

   snap_rise_det #(.RESET_LEVEL(REF_RESET_LEVEL)) u_rise (
      .clk   (clk_div),
      .rst_n (rst_n),
      .lvl   (ref_dly),
      .rise  (rise)
   );

   snap_arm_ctl u_arm (
      .clk      (clk_div),
      .rst_n    (rst_n),
      .rise     (rise),
      .osc_edge (osc_edge),
      .capture  (capture),
      .cap_q    (cap_edge),
      .done     (cap_done),
      .missed_q (edge_missed)
   );

   // The reference level is sampled by the captured edge itself.
   snap_retime_pipe #(.LAT(RETIME_LAT)) u_rt (
      .clk     (clk_div),
      .rst_n   (rst_n),
      .adv     (osc_edge),
      .sample  (capture & ref_dly),
      .pulse_q (ref_rt)
   );
endmodule

// File: rtl/snap_edge_capture_chk.sv
module snap_edge_capture_chk (
   input logic clk_div,
   input logic rst_n,
   input logic ref_dly,
   input logic osc_edge,
   input logic cap_edge,
   input logic ref_rt,
   input logic cap_done,
   input logic edge_missed
);
   assert_cap_from_edge_R1: assert property (@(posedge clk_div) disable iff (!rst_n)
      cap_edge |-> $past(osc_edge));
   assert_single_cap_R2: assert property (@(posedge clk_div) disable iff (!rst_n)
      cap_edge |=> !cap_edge);
   assert_rt_on_edge_R3: assert property (@(posedge clk_div) disable iff (!rst_n)
      ref_rt |-> $past(osc_edge));
   assert_done_with_cap_R4: assert property (@(posedge clk_div) disable iff (!rst_n)
      cap_edge |-> cap_done);
   assert_missed_pulse_R5: assert property (@(posedge clk_div) disable iff (!rst_n)
      edge_missed |=> !edge_missed);
   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R6: assert (!cap_edge && !ref_rt && !cap_done && !edge_missed);
      end
   end
endmodule

bind snap_edge_capture snap_edge_capture_chk u_chk (.*);

// File: tb/tb_snap_edge_capture.sv
module tb_snap_edge_capture;
   localparam int PER = 10;
   localparam int LAT = 2;

   logic clk_div = 1'b0;
   logic rst_n   = 1'b0;
   logic ref_dly = 1'b0;
   logic osc_edge = 1'b0;
   logic cap_edge, ref_rt, cap_done, edge_missed;

   int n_chk = 0;
   int n_bad = 0;

   snap_edge_capture #(.RETIME_LAT(LAT)) dut (
      .clk_div     (clk_div),
      .rst_n       (rst_n),
      .ref_dly     (ref_dly),
      .osc_edge    (osc_edge),
      .cap_edge    (cap_edge),
      .ref_rt      (ref_rt),
      .cap_done    (cap_done),
      .edge_missed (edge_missed)
   );

   always #(PER/2) clk_div = ~clk_div;

   task automatic chk(input logic got, input logic exp, input string req, input string what);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic tick(input logic r, input logic o);
      ref_dly  = r;
      osc_edge = o;
      @(posedge clk_div);
      #1;
   endtask

   initial begin
      #(PER*200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic prev_done;
      // R6: reset with reference held high
      ref_dly = 1'b1; osc_edge = 1'b1;
      repeat (3) @(posedge clk_div);
      #1;
      chk(cap_edge, 1'b0, "R6", "cap_edge in reset");
      chk(ref_rt, 1'b0, "R6", "ref_rt in reset");
      chk(cap_done, 1'b0, "R6", "cap_done in reset");
      chk(edge_missed, 1'b0, "R6", "edge_missed in reset");
      rst_n = 1'b1;
      tick(1'b1, 1'b1);
      chk(cap_edge, 1'b0, "R6", "high level at release not a rise");
      chk(cap_done, 1'b0, "R4", "idle done flag");
      tick(1'b0, 1'b1);
      chk(cap_edge, 1'b0, "R6", "still disarmed");
      prev_done = 1'b0;

      // Sweep: rise-to-edge gap D, edge spacing P, reference high length H
      for (int d = 0; d <= 4; d++) begin
         for (int p = 1; p <= 3; p++) begin
            for (int hs = 0; hs < 3; hs++) begin
               int h;
               int n;
               h = (hs == 0) ? 1 : (hs == 1) ? 2 : 6;
               n = d + LAT*p + 2;
               for (int k = 0; k < 4; k++) begin
                  tick(1'b0, 1'b1);
                  chk(cap_edge, 1'b0, "R2", "edge ignored while disarmed");
                  chk(cap_done, prev_done, "R4", "done held between periods");
                  chk(ref_rt, 1'b0, "R3", "no stray retimed pulse");
               end
               for (int i = 0; i < n; i++) begin
                  logic o;
                  o = (i >= d) && (((i - d) % p) == 0);
                  tick(i < h, o);
                  chk(cap_edge, (i == d), (i > d) ? "R2" : "R1", "cap_edge");
                  chk(ref_rt, (d < h) && (i == d + LAT*p), "R3", "ref_rt");
                  chk(cap_done, (i >= d), "R4", "cap_done");
                  chk(edge_missed, 1'b0, "R5", "no missed edge");
               end
               prev_done = 1'b1;
            end
         end
      end

      // R5: two rises with no divided edge between them
      tick(1'b0, 1'b0);
      tick(1'b1, 1'b0);
      chk(edge_missed, 1'b0, "R5", "first rise from done");
      chk(cap_done, 1'b0, "R4", "cleared at rise");
      tick(1'b0, 1'b0);
      tick(1'b1, 1'b0);
      chk(edge_missed, 1'b1, "R5", "rise while armed");
      tick(1'b1, 1'b0);
      chk(edge_missed, 1'b0, "R5", "missed is one cycle");
      tick(1'b1, 1'b1);
      chk(cap_edge, 1'b1, "R5", "still armed after miss");
      chk(cap_done, 1'b1, "R4", "done after capture");
      tick(1'b0, 1'b1);
      chk(cap_edge, 1'b0, "R2", "second edge dropped");
      tick(1'b0, 1'b1);
      chk(ref_rt, 1'b1, "R3", "retimed after second edge");
      tick(1'b0, 1'b1);
      chk(ref_rt, 1'b0, "R3", "retimed pulse one cycle");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule